// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host that sees a 64-bit register window reach a small remote space of 32-bit registers through a command-and-poll handshake. The host first loads the value to send into a write-data register. It then writes a command word that holds a remote word address and a request flag. The word address is the remote byte offset divided by four. The host polls the command register until the request flag reads back clear. For a read, it then collects the returned value from a read-data register.

On the remote side, a request/acknowledge port presents the word address, the write value and a read or write strobe. The strobe stays high until the far end acknowledges, and the far end may take any number of cycles to do so. Read data is taken in on the acknowledge cycle. The window also holds a read-only capability word that describes the serial engine behind the bridge. Every field of the capability word is fixed by a parameter at elaboration.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, nothing is pending: `dn_wr` and `dn_rd` are low, and the command (0x10), read-data (0x18) and write-data (0x20) registers all read zero.
- R2: Offset 0x08 reads the capability word, and host writes to it have no effect. Its fields are:
  - bit 1: shift order;
  - bits 7:2: data width;
  - bits 13:8: chip-select count;
  - bit 14: clock polarity;
  - bit 15: clock phase;
  - bits 31:22: serial clock field;
  - bits 47:32: peripheral ID;
  - all other bits: zero.
- R3: A command write to 0x10 while idle, with bit 8 set, starts a write. From the next cycle `dn_wr` is high, `dn_addr` equals command bits 7:0 and `dn_wdata` equals the write-data register. Command readback shows bit 8 set and the address in bits 7:0.
- R4: A strobe, its address and its write data stay unchanged until the first cycle with `dn_ack` high. In the cycle after that acknowledge, the strobe is low and the request bit reads zero.
- R5: A command with bit 9 set, and bit 8 clear, starts a read on `dn_rd`. The `dn_rdata` value present with the acknowledge then reads back at 0x18 in bits 31:0. Bits 63:32 of 0x18, including the reserved debug bit 32, read zero.
- R6: A command with both bit 8 and bit 9 set starts a write only.
- R7: A command write while a request is pending is ignored: the address, the request bits and the strobes are unchanged.
- R8: Writes to 0x20 store bits 31:0, and 0x20 reads them back. Such a write is ignored while a write request is pending.
- R9: `dn_ack` while idle has no effect: 0x18 keeps its value and no strobe starts.
- R10: Any offset other than 0x08, 0x10, 0x18 and 0x20 reads zero, including unaligned offsets.
- R11: A command with neither bit 8 nor bit 9 set, written while idle, loads the address field and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | HOST_AW | Host byte offset into the window |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 64 | Host write value |
| host_rdata | output | 64 | Host read value for `host_addr` (combinational) |
| dn_addr | output | RADDR_W | Remote word address |
| dn_wdata | output | REG_W | Remote write value |
| dn_wr | output | 1 | Remote write strobe, held until acknowledge |
| dn_rd | output | 1 | Remote read strobe, held until acknowledge |
| dn_ack | input | 1 | Remote acknowledge |
| dn_rdata | input | REG_W | Remote read value, taken in on acknowledge |

## Verification
The bench aims at three kinds of stimulus.

- **Commands during an outstanding request.** It issues new commands and new write data while a request is still outstanding. A bridge that accepted them would retarget or corrupt a transaction in flight, and `dn_addr` or `dn_wdata` would move under a held strobe.
- **Acknowledge timing.** It gives acknowledges after zero, short and long waits, and also gives acknowledges while idle. A design that took in data on a stray acknowledge, or that released the strobe early, would show a wrong 0x18 value or a strobe that drops too soon.
- **Command word corner cases.** It sends a command with both request bits set and one with neither. A priority swap would raise `dn_rd`. A bridge that ignored address-only commands would read back a stale address.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

   // Host window width and register offsets (byte offsets)
   localparam int HOST_DW = 64;
   localparam int OFF_CAP = 8'h08;
   localparam int OFF_CMD = 8'h10;
   localparam int OFF_RDV = 8'h18;
   localparam int OFF_WDV = 8'h20;

   // Command word bit positions
   localparam int CMD_WR_BIT = 8;
   localparam int CMD_RD_BIT = 9;
   localparam int CMD_W      = 10;

   // Capability word field positions
   localparam int CAP_SHIFT_LSB = 1;
   localparam int CAP_DW_LSB    = 2;
   localparam int CAP_NCS_LSB   = 8;
   localparam int CAP_CPOL_LSB  = 14;
   localparam int CAP_CPHA_LSB  = 15;
   localparam int CAP_CLK_LSB   = 22;
   localparam int CAP_PID_LSB   = 32;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_WR   = 2'd1,
      XS_RD   = 2'd2
   } xfer_state_t;

endpackage

// File: rtl/ibr_cap_word.sv
module ibr_cap_word #(
   parameter int SHIFT_LSB_FIRST = 0,
   parameter int DATA_BITS       = 32,
   parameter int NUM_CS          = 1,
   parameter int CLK_POL         = 0,
   parameter int CLK_PHA         = 0,
   parameter int SCLK_FIELD      = 0,
   parameter int PERIPH_ID       = 0
) (
   output logic [ibr_pkg::HOST_DW-1:0] cap
);
   import ibr_pkg::*;

   // Elaboration-time range checks on every field
   generate
      if (SHIFT_LSB_FIRST < 0 || SHIFT_LSB_FIRST > 1) begin : g_bad_shift
         $error("SHIFT_LSB_FIRST must be 0 or 1");
      end
      if (DATA_BITS < 1 || DATA_BITS > 63) begin : g_bad_dw
         $error("DATA_BITS must fit in 6 bits and be nonzero");
      end
      if (NUM_CS < 0 || NUM_CS > 63) begin : g_bad_ncs
         $error("NUM_CS must fit in 6 bits");
      end
      if (CLK_POL < 0 || CLK_POL > 1 || CLK_PHA < 0 || CLK_PHA > 1) begin : g_bad_mode
         $error("clock mode fields must be 0 or 1");
      end
      if (SCLK_FIELD < 0 || SCLK_FIELD > 1023) begin : g_bad_clk
         $error("SCLK_FIELD must fit in 10 bits");
      end
      if (PERIPH_ID < 0 || PERIPH_ID > 65535) begin : g_bad_pid
         $error("PERIPH_ID must fit in 16 bits");
      end
   endgenerate

   always_comb begin
      cap = '0;
      cap[CAP_SHIFT_LSB]              = 1'(SHIFT_LSB_FIRST);
      cap[CAP_DW_LSB +: 6]            = 6'(DATA_BITS);
      cap[CAP_NCS_LSB +: 6]           = 6'(NUM_CS);
      cap[CAP_CPOL_LSB]               = 1'(CLK_POL);
      cap[CAP_CPHA_LSB]               = 1'(CLK_PHA);
      cap[CAP_CLK_LSB +: 10]          = 10'(SCLK_FIELD);
      cap[CAP_PID_LSB +: 16]          = 16'(PERIPH_ID);
   end

endmodule

// File: rtl/ibr_wdata_hold.sv
module ibr_wdata_hold #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] d,
   input  logic             hold,
   output logic [REG_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we && !hold) begin
         q <= d;
      end
   end

   // R8
   wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && we) |=> $stable(q));

endmodule

// File: rtl/ibr_cmd_ctrl.sv
module ibr_cmd_ctrl #(
   parameter int RADDR_W = 8,
   parameter int REG_W   = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_we,
   input  logic [ibr_pkg::CMD_W-1:0]   cmd_word,
   input  logic                        dn_ack,
   input  logic [REG_W-1:0]            dn_rdata,
   output logic [RADDR_W-1:0]          dn_addr,
   output logic                        dn_wr,
   output logic                        dn_rd,
   output logic [REG_W-1:0]            rd_value,
   output logic                        wr_busy
);
   import ibr_pkg::*;

   xfer_state_t          state_q;
   logic [RADDR_W-1:0]   addr_q;
   logic [REG_W-1:0]     rdat_q;
   logic                 busy;

   generate
      if (RADDR_W < CMD_WR_BIT) begin : g_addr_gap
         logic unused_gap;
         assign unused_gap = ^cmd_word[CMD_WR_BIT-1:RADDR_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         addr_q  <= '0;
         rdat_q  <= '0;
      end else begin
         case (state_q)
            XS_IDLE: begin
               if (cmd_we) begin
                  addr_q <= cmd_word[RADDR_W-1:0];
                  if (cmd_word[CMD_WR_BIT]) begin
                     state_q <= XS_WR;
                  end else if (cmd_word[CMD_RD_BIT]) begin
                     state_q <= XS_RD;
                  end
               end
            end
            XS_WR: begin
               if (dn_ack) state_q <= XS_IDLE;
            end
            XS_RD: begin
               if (dn_ack) begin
                  state_q <= XS_IDLE;
                  rdat_q  <= dn_rdata;
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != XS_IDLE);
   assign dn_wr    = (state_q == XS_WR);
   assign dn_rd    = (state_q == XS_RD);
   assign dn_addr  = addr_q;
   assign rd_value = rdat_q;
   assign wr_busy  = dn_wr;

   // R4
   hold_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dn_wr || dn_rd) && !dn_ack) |=> (dn_wr == $past(dn_wr)) && (dn_rd == $past(dn_rd)));

   // R4
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dn_wr || dn_rd) && !dn_ack) |=> $stable(dn_addr));

   // R4
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dn_wr || dn_rd) && dn_ack) |=> !(dn_wr || dn_rd));

   // R5
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_rd && dn_ack) |=> (rd_value == $past(dn_rdata)));

   // R6
   write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_we && cmd_word[CMD_WR_BIT] && cmd_word[CMD_RD_BIT]) |=> (dn_wr && !dn_rd));

   // R7
   busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we && !dn_ack) |=> $stable(dn_addr) && $stable(dn_wr) && $stable(dn_rd));

   // R9
   idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_we && dn_ack) |=> $stable(rd_value) && !dn_wr && !dn_rd);

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge #(
   parameter int HOST_AW         = 6,
   parameter int RADDR_W         = 8,
   parameter int REG_W           = 32,
   parameter int SHIFT_LSB_FIRST = 0,
   parameter int DATA_BITS       = 32,
   parameter int NUM_CS          = 1,
   parameter int CLK_POL         = 0,
   parameter int CLK_PHA         = 0,
   parameter int SCLK_FIELD      = 0,
   parameter int PERIPH_ID       = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [HOST_AW-1:0]           host_addr,
   input  logic                         host_we,
   input  logic [ibr_pkg::HOST_DW-1:0]  host_wdata,
   output logic [ibr_pkg::HOST_DW-1:0]  host_rdata,
   output logic [RADDR_W-1:0]           dn_addr,
   output logic [REG_W-1:0]             dn_wdata,
   output logic                         dn_wr,
   output logic                         dn_rd,
   input  logic                         dn_ack,
   input  logic [REG_W-1:0]             dn_rdata
);
   import ibr_pkg::*;

   generate
      if (HOST_AW < 6) begin : g_bad_aw
         $error("HOST_AW too small to reach offset 0x20");
      end
      if (RADDR_W < 1 || RADDR_W > CMD_WR_BIT) begin : g_bad_raw
         $error("RADDR_W must sit below the write request bit");
      end
      if (REG_W < CMD_W || REG_W > 32) begin : g_bad_regw
         $error("REG_W must be between 10 and 32");
      end
   endgenerate

   localparam logic [HOST_AW-1:0] A_CAP = HOST_AW'(OFF_CAP);
   localparam logic [HOST_AW-1:0] A_CMD = HOST_AW'(OFF_CMD);
   localparam logic [HOST_AW-1:0] A_RDV = HOST_AW'(OFF_RDV);
   localparam logic [HOST_AW-1:0] A_WDV = HOST_AW'(OFF_WDV);

   logic [HOST_DW-1:0] cap_word;
   logic [REG_W-1:0]   rd_value;
   logic               wr_busy;
   logic               cmd_we;
   logic               wdv_we;
   logic               unused_hi_bits;

   assign cmd_we = host_we && (host_addr == A_CMD);
   assign wdv_we = host_we && (host_addr == A_WDV);
   assign unused_hi_bits = ^host_wdata[HOST_DW-1:REG_W];

   ibr_cap_word #(
      .SHIFT_LSB_FIRST (SHIFT_LSB_FIRST),
      .DATA_BITS       (DATA_BITS),
      .NUM_CS          (NUM_CS),
      .CLK_POL         (CLK_POL),
      .CLK_PHA         (CLK_PHA),
      .SCLK_FIELD      (SCLK_FIELD),
      .PERIPH_ID       (PERIPH_ID)
   ) i_cap (
      .cap (cap_word)
   );

   ibr_wdata_hold #(
      .REG_W (REG_W)
   ) i_wdv (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wdv_we),
      .d     (host_wdata[REG_W-1:0]),
      .hold  (wr_busy),
      .q     (dn_wdata)
   );

   ibr_cmd_ctrl #(
      .RADDR_W (RADDR_W),
      .REG_W   (REG_W)
   ) i_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_word (host_wdata[CMD_W-1:0]),
      .dn_ack   (dn_ack),
      .dn_rdata (dn_rdata),
      .dn_addr  (dn_addr),
      .dn_wr    (dn_wr),
      .dn_rd    (dn_rd),
      .rd_value (rd_value),
      .wr_busy  (wr_busy)
   );

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         A_CAP: host_rdata = cap_word;
         A_CMD: begin
            host_rdata[RADDR_W-1:0] = dn_addr;
            host_rdata[CMD_WR_BIT]  = dn_wr;
            host_rdata[CMD_RD_BIT]  = dn_rd;
         end
         A_RDV: host_rdata[REG_W-1:0] = rd_value;
         A_WDV: host_rdata[REG_W-1:0] = dn_wdata;
         default: host_rdata = '0;
      endcase
   end

endmodule

// File: tb/test_ibr_bridge.sv
module test_ibr_bridge;

   localparam int P_SHIFT = 1;
   localparam int P_DW    = 32;
   localparam int P_NCS   = 5;
   localparam int P_CPOL  = 1;
   localparam int P_CPHA  = 0;
   localparam int P_SCLK  = 677;
   localparam int P_PID   = 48879;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  host_addr = '0;
   logic        host_we = 1'b0;
   logic [63:0] host_wdata = '0;
   logic [63:0] host_rdata;
   logic [7:0]  dn_addr;
   logic [31:0] dn_wdata;
   logic        dn_wr;
   logic        dn_rd;
   logic        dn_ack = 1'b0;
   logic [31:0] dn_rdata = '0;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // behavioural reference state
   bit          m_wr, m_rd;
   int unsigned m_addr, m_wdat, m_rdat;
   longint unsigned exp_cap;

   always #2 clk = ~clk;

   ibr_bridge #(
      .SHIFT_LSB_FIRST (P_SHIFT), .DATA_BITS (P_DW), .NUM_CS (P_NCS),
      .CLK_POL (P_CPOL), .CLK_PHA (P_CPHA), .SCLK_FIELD (P_SCLK), .PERIPH_ID (P_PID)
   ) i_ibr_bridge (
      .clk (clk), .rst_n (rst_n), .host_addr (host_addr), .host_we (host_we),
      .host_wdata (host_wdata), .host_rdata (host_rdata), .dn_addr (dn_addr),
      .dn_wdata (dn_wdata), .dn_wr (dn_wr), .dn_rd (dn_rd), .dn_ack (dn_ack),
      .dn_rdata (dn_rdata)
   );

   initial begin
      exp_cap = (longint'(P_SHIFT) << 1) | (longint'(P_DW) << 2) | (longint'(P_NCS) << 8)
              | (longint'(P_CPOL) << 14) | (longint'(P_CPHA) << 15)
              | (longint'(P_SCLK) << 22) | (longint'(P_PID) << 32);
   end

   // reference model update
   always @(posedge clk) begin
      bit busy_old, wr_old;
      busy_old = m_wr || m_rd;
      wr_old   = m_wr;
      if (!rst_n) begin
         m_wr = 0; m_rd = 0; m_addr = 0; m_wdat = 0; m_rdat = 0;
      end else begin
         if (busy_old && dn_ack) begin
            if (m_rd) m_rdat = dn_rdata;
            m_wr = 0; m_rd = 0;
         end else if (!busy_old && host_we && host_addr == 6'h10) begin
            m_addr = host_wdata[7:0];
            if (host_wdata[8]) m_wr = 1;
            else if (host_wdata[9]) m_rd = 1;
         end
         if (host_we && host_addr == 6'h20 && !wr_old) m_wdat = host_wdata[31:0];
      end
   end

   function automatic longint unsigned exp_read(input logic [5:0] a);
      case (a)
         6'h08: return exp_cap;
         6'h10: return (longint'(m_rd) << 9) | (longint'(m_wr) << 8) | longint'(m_addr);
         6'h18: return longint'(m_rdat);
         6'h20: return longint'(m_wdat);
         default: return 0;
      endcase
   endfunction

   function automatic string tag_for(input logic [5:0] a);
      case (a)
         6'h08: return "R2";
         6'h10: return "R3 R7 R11";
         6'h18: return "R5 R9";
         6'h20: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input longint unsigned act, input longint unsigned exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3 R4 R5 R6", "dn_wr", longint'(dn_wr), longint'(m_wr));
         check("R5 R6 R9", "dn_rd", longint'(dn_rd), longint'(m_rd));
         check("R3 R4 R7", "dn_addr", longint'(dn_addr), longint'(m_addr));
         check("R3 R4 R8", "dn_wdata", longint'(dn_wdata), longint'(m_wdat));
         check(tag_for(host_addr), "host_rdata", host_rdata, exp_read(host_addr));
      end
   end

   task automatic cyc();
      @(negedge clk); #1;
   endtask

   task automatic hwrite(input logic [5:0] a, input longint unsigned d);
      cyc();
      host_we = 1'b1; host_addr = a; host_wdata = d;
      cyc();
      host_we = 1'b0;
   endtask

   task automatic look(input logic [5:0] a, input int n);
      host_addr = a;
      repeat (n) cyc();
   endtask

   task automatic ack_after(input int n, input logic [31:0] d);
      repeat (n) cyc();
      dn_ack = 1'b1; dn_rdata = d;
      cyc();
      dn_ack = 1'b0; dn_rdata = 32'h0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog all requirements: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      cyc();
      rst_n = 1'b1;
      // R1 reset state
      cyc();
      check("R1", "dn_wr after reset", longint'(dn_wr), 0);
      check("R1", "dn_rd after reset", longint'(dn_rd), 0);
      foreach (m_addr_list[i]) begin
         host_addr = m_addr_list[i];
         #1;
         check("R1", "register after reset", host_rdata, 0);
      end
      // R2 capability and write ignored
      look(6'h08, 2);
      check("R2", "capability word", host_rdata, exp_cap);
      hwrite(6'h08, 64'hFFFF_FFFF_FFFF_FFFF);
      look(6'h08, 2);
      check("R2", "capability after write", host_rdata, exp_cap);
      // R8 load write data, R3 write with wait, R7 busy command, R8 busy data write
      hwrite(6'h20, 64'h1111_2222_CAFE_F00D);
      look(6'h20, 1);
      hwrite(6'h10, 64'h0000_0000_0000_0103);
      look(6'h10, 2);
      check("R3", "write request bit set", host_rdata, 64'h103);
      hwrite(6'h10, 64'h0000_0000_0000_0207);
      hwrite(6'h20, 64'h0000_0000_DEAD_BEEF);
      look(6'h20, 1);
      check("R8", "write data held while busy", host_rdata, 64'hCAFE_F00D);
      ack_after(3, 32'h5555_5555);
      look(6'h10, 1);
      check("R4", "write request cleared", host_rdata, 64'h003);
      // R5 read, zero wait
      hwrite(6'h10, 64'h0000_0000_0000_0205);
      ack_after(0, 32'h1234_5678);
      look(6'h18, 1);
      check("R5", "read value", host_rdata, 64'h1234_5678);
      // R5 read, long wait, then R9 stray ack
      hwrite(6'h10, 64'h0000_0000_0000_0206);
      look(6'h10, 1);
      check("R5", "read request bit set", host_rdata, 64'h206);
      ack_after(20, 32'hA5A5_5A5A);
      look(6'h18, 1);
      check("R5", "read value long wait", host_rdata, 64'hA5A5_5A5A);
      ack_after(2, 32'h0BAD_0BAD);
      look(6'h18, 1);
      check("R9", "idle ack ignored", host_rdata, 64'hA5A5_5A5A);
      // R6 both bits set
      hwrite(6'h20, 64'h0000_0000_7777_8888);
      hwrite(6'h10, 64'h0000_0000_0000_0304);
      look(6'h10, 1);
      check("R6", "both bits gives write", host_rdata, 64'h104);
      ack_after(1, 32'h0);
      // R11 neither bit
      hwrite(6'h10, 64'hFFFF_FFFF_FFFF_FC2A);
      look(6'h10, 2);
      check("R11", "address-only command", host_rdata, 64'h02A);
      // R10 unmapped offsets
      look(6'h00, 1);
      check("R10", "offset 0x00", host_rdata, 0);
      look(6'h09, 1);
      check("R10", "offset 0x09", host_rdata, 0);
      look(6'h28, 1);
      check("R10", "offset 0x28", host_rdata, 0);
      look(6'h3F, 1);
      check("R10", "offset 0x3F", host_rdata, 0);
      // back to back: read then write
      hwrite(6'h10, 64'h0000_0000_0000_0201);
      ack_after(0, 32'hFEED_FACE);
      hwrite(6'h10, 64'h0000_0000_0000_0102);
      ack_after(5, 32'h0);
      look(6'h18, 2);
      check("R5", "read value kept after write", host_rdata, 64'hFEED_FACE);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   logic [5:0] m_addr_list [3] = '{6'h10, 6'h18, 6'h20};

endmodule